// File: doc/BRIEF.md
# PCI Target Parity Checker and Error Reporter

This block watches the shared 32-bit address/data bus of a PCI target and checks even parity over AD, C/BE# and PAR. It checks address phases whenever the device is not itself the bus master. It also checks the data phases of writes that target the device. PAR covers the lines of the previous clock, so each check compares a parity captured on one edge with the PAR value sampled on the next edge.

Errors are reported in two ways. Address parity errors pulse SERR# and hold back the device's DEVSEL#. Data parity errors pulse PERR#, and the block owns the output enable of that sustained tri-state line. Both kinds of error set sticky status flags, which software clears by writing ones. The write data itself is never held back or altered: the transfer completes normally.

Top module: `pci_parity_guard`

## Requirements
- R1: An address phase is checked only on an edge where `addr_phase`=1 and `bus_master`=0. The check is even parity: the count of ones in `ad`, `cbe_n` and the following cycle's `par` must be even.
- R2: `par` is sampled on the edge after the one that captures `ad`/`cbe_n`. The value of `ad` on that later edge has no effect on the result.
- R3: Any detected parity error, address or data, sets `stat_dpe` on the second edge after the checked edge. This happens regardless of `perr_en` and `serr_en`.
- R4: On an address parity error with `perr_en`=1 and `serr_en`=1, `serr_n` is low for exactly one clock, starting on the second edge after the address edge. `stat_sse` is set on that same edge. With either enable at 0, `serr_n` stays high and `stat_sse` stays 0.
- R5: When both enables are 1, `devsel_inhibit` is high from the clock after an errored address edge. It stays high until an edge that samples `frame_n`=1 and `irdy_n`=1. In every other case it stays 0.
- R6: A data phase is checked only on an edge where `wr_cmd`=1, `bus_master`=0, `irdy_n`=0 and `trdy_n`=0.
- R7: On a data parity error with `perr_en`=1, `perr_n` is low for exactly one clock, starting on the second edge after the transfer edge. With `perr_en`=0 it stays high.
- R8: `perr_oe` rises on the edge of a checked write transfer. It stays high through the check pipeline and for one extra clock after any low pulse of `perr_n`, so that the line is driven high before release. `perr_n` is never low while `perr_oe` is 0.
- R9: `stat_dpe` and `stat_sse` stay set until `clr_dpe`/`clr_sse` is 1 on an edge. A set on the same edge as a clear wins.
- R10: After reset, `perr_n`=1, `serr_n`=1, `perr_oe`=0, `devsel_inhibit`=0, `stat_dpe`=0 and `stat_sse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad | input | 32 | Address/data lines |
| cbe_n | input | 4 | Command / byte-enable lines |
| par | input | 1 | Parity line, covering the previous cycle |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| bus_master | input | 1 | This device currently owns the bus |
| addr_phase | input | 1 | Strobe marking the address-phase cycle |
| wr_cmd | input | 1 | Current transaction is a write that targets this device |
| perr_en | input | 1 | Parity error response enable |
| serr_en | input | 1 | System error enable |
| clr_dpe | input | 1 | Write-one-to-clear for the detected-parity flag |
| clr_sse | input | 1 | Write-one-to-clear for the signalled-system-error flag |
| perr_n | output | 1 | PERR# level |
| perr_oe | output | 1 | PERR# output enable |
| serr_n | output | 1 | SERR#, active low pulse |
| devsel_inhibit | output | 1 | Blocks DEVSEL# for the current transaction |
| stat_dpe | output | 1 | Sticky detected-parity-error flag |
| stat_sse | output | 1 | Sticky signalled-system-error flag |

## Verification
Two events can fall on the same edge: a software clear of a status flag and the setting of that flag by a fresh error. The bench provokes this by pulsing both clears on exactly the edge where an address error sets both flags. It then judges that both flags read 1 afterwards, and that a later clear takes them back to 0. A sweep flips each of the 36 covered lines and PAR one at a time, under every enable combination and for both phase kinds. Every pulse, enable and flag is compared against values derived from the flipped-bit count.

// File: rtl/pci_par_pkg.sv
// Shared widths and result type for the PCI parity checker.
// Assumes a 32-bit bus with four command/byte-enable lines.
package pci_par_pkg;
    localparam int PCI_AD_W = 32;
    localparam int PCI_BE_W = 4;

    // Outcome of one parity comparison, valid on the cycle after PAR was sampled
    typedef struct packed {
        logic valid;
        logic err;
    } par_result_t;
endpackage

// File: rtl/par_stage.sv
// Two-edge parity comparator: it captures the XOR of the covered lines when
// `sample` is high, and on the next edge compares it with PAR.
// Assumes PAR trails the lines it covers by exactly one clock (even parity).
module par_stage #(
    parameter int W = 36
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample,
    input  logic [W-1:0]             vec,
    input  logic                     par,
    output logic                     cap_valid,
    output pci_par_pkg::par_result_t result
);
    logic cap_xor;

    // Capture the line parity, then compare it against PAR one edge later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_xor   <= 1'b0;
            result    <= '0;
        end else begin
            cap_valid    <= sample;
            cap_xor      <= ^vec;
            result.valid <= cap_valid;
            result.err   <= cap_valid & (cap_xor ^ par);
        end
    end
endmodule

// File: rtl/sticky_flag.sv
// Write-one-to-clear status bit; a set on the same edge as a clear wins.
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag until it is cleared, with set taking priority
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/pci_parity_guard.sv
// PCI target parity checker and reporter. Address phases are checked when
// the device is not the master. Write data phases are checked on the IRDY#/TRDY#
// transfer edge. Reports go out on SERR#/PERR# two edges after the checked edge.
// Assumes addr_phase marks exactly the address cycle and wr_cmd stays stable
// for the whole target write.
module pci_parity_guard #(
    parameter int AD_W = pci_par_pkg::PCI_AD_W,
    parameter int BE_W = pci_par_pkg::PCI_BE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe_n,
    input  logic            par,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic            trdy_n,
    input  logic            bus_master,
    input  logic            addr_phase,
    input  logic            wr_cmd,
    input  logic            perr_en,
    input  logic            serr_en,
    input  logic            clr_dpe,
    input  logic            clr_sse,
    output logic            perr_n,
    output logic            perr_oe,
    output logic            serr_n,
    output logic            devsel_inhibit,
    output logic            stat_dpe,
    output logic            stat_sse
);
    import pci_par_pkg::*;

    localparam int VEC_W = AD_W + BE_W;

    logic [VEC_W-1:0] bus_vec;
    logic             addr_smp, data_smp;
    logic             a_cap, d_cap;
    par_result_t      a_res, d_res;
    logic             both_en, addr_report, inhib_q, perr_q, serr_q, oe_q;

    assign bus_vec  = {cbe_n, ad};
    assign addr_smp = addr_phase & ~bus_master;
    assign data_smp = wr_cmd & ~bus_master & ~irdy_n & ~trdy_n;
    assign both_en  = perr_en & serr_en;
    assign addr_report = a_res.err & both_en;

    par_stage #(.W(VEC_W)) u_addr_chk (
        .clk(clk), .rst_n(rst_n), .sample(addr_smp), .vec(bus_vec),
        .par(par), .cap_valid(a_cap), .result(a_res)
    );

    par_stage #(.W(VEC_W)) u_data_chk (
        .clk(clk), .rst_n(rst_n), .sample(data_smp), .vec(bus_vec),
        .par(par), .cap_valid(d_cap), .result(d_res)
    );

    // Register the SERR#/PERR# pulses one edge after the comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serr_q <= 1'b1;
            perr_q <= 1'b1;
        end else begin
            serr_q <= ~addr_report;
            perr_q <= ~(d_res.err & perr_en);
        end
    end

    // Hold DEVSEL# back from an errored address until the bus goes idle
    always_ff @(posedge clk) begin
        if (!rst_n)                 inhib_q <= 1'b0;
        else if (addr_report)       inhib_q <= 1'b1;
        else if (frame_n & irdy_n)  inhib_q <= 1'b0;
    end

    // Drive PERR# during write data phases, the check pipeline and one recovery clock
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= (wr_cmd & ~bus_master & (~frame_n | ~irdy_n))
                            | d_cap | d_res.valid | ~perr_q;
    end

    sticky_flag u_dpe (
        .clk(clk), .rst_n(rst_n), .set(a_res.err | d_res.err),
        .clr(clr_dpe), .q(stat_dpe)
    );

    sticky_flag u_sse (
        .clk(clk), .rst_n(rst_n), .set(addr_report),
        .clr(clr_sse), .q(stat_sse)
    );

    assign serr_n         = serr_q;
    assign perr_n         = perr_q;
    assign perr_oe        = oe_q;
    assign devsel_inhibit = inhib_q | addr_report;
endmodule

// File: rtl/pci_parity_guard_chk.sv
// Property checker for pci_parity_guard, attached by bind.
module pci_parity_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic perr_en,
    input logic serr_en,
    input logic clr_dpe,
    input logic clr_sse,
    input logic frame_n,
    input logic irdy_n,
    input logic perr_n,
    input logic perr_oe,
    input logic serr_n,
    input logic devsel_inhibit,
    input logic stat_dpe,
    input logic stat_sse
);
    AST_SERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |=> serr_n); // R4
    AST_SERR_SETS_SSE: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> stat_sse); // R4
    AST_SERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(perr_en && serr_en)); // R4
    AST_SERR_SETS_DPE: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> stat_dpe); // R3
    AST_SERR_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> devsel_inhibit || $past(frame_n && irdy_n)); // R5
    AST_PERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |=> perr_n); // R7
    AST_PERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(perr_en)); // R7
    AST_PERR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> perr_oe); // R8
    AST_PERR_HIGH_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr_n) |-> perr_oe); // R8
    AST_PERR_SETS_DPE: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> stat_dpe); // R3
    AST_DPE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_dpe && !clr_dpe) |=> stat_dpe); // R9
    AST_SSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sse && !clr_sse) |=> stat_sse); // R9
endmodule

bind pci_parity_guard pci_parity_guard_chk u_chk (.*);

// File: tb/tb_pci_parity_guard.sv
`timescale 1ns/1ps
module tb_pci_parity_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ad;
    logic [3:0]  cbe_n;
    logic        par, frame_n, irdy_n, trdy_n, bus_master, addr_phase, wr_cmd;
    logic        perr_en, serr_en, clr_dpe, clr_sse;
    logic        perr_n, perr_oe, serr_n, devsel_inhibit, stat_dpe, stat_sse;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    pci_parity_guard dut (
        .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n), .par(par),
        .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
        .bus_master(bus_master), .addr_phase(addr_phase), .wr_cmd(wr_cmd),
        .perr_en(perr_en), .serr_en(serr_en), .clr_dpe(clr_dpe), .clr_sse(clr_sse),
        .perr_n(perr_n), .perr_oe(perr_oe), .serr_n(serr_n),
        .devsel_inhibit(devsel_inhibit), .stat_dpe(stat_dpe), .stat_sse(stat_sse)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_bus();
        addr_phase = 0; wr_cmd = 0; frame_n = 1; irdy_n = 1; trdy_n = 1;
        bus_master = 0; clr_dpe = 0; clr_sse = 0;
    endtask

    // Clear both flags and confirm they read 0 (R9)
    task automatic clear_flags();
        clr_dpe = 1; clr_sse = 1;
        @(negedge clk);
        clr_dpe = 0; clr_sse = 0;
        check("R9 dpe cleared", stat_dpe, 1'b0);
        check("R9 sse cleared", stat_sse, 1'b0);
    endtask

    // flip: 0..31 AD bit, 32..35 C/BE# bit, 36 PAR, 37 none
    task automatic addr_txn(input logic pe, input logic se, input int flip,
                            input logic master, input logic clr_same);
        logic [31:0] a;
        logic [3:0]  c;
        logic        p, err, rep;
        a = 32'h9E3779B9 * (flip + 3) ^ {28'h0, pe, se, 2'b01};
        c = 4'(flip * 5 + 6);
        p = ^{a, c};
        if (flip < 32)      a[flip] = ~a[flip];
        else if (flip < 36) c[flip-32] = ~c[flip-32];
        else if (flip == 36) p = ~p;
        err = (flip != 37) && !master;
        rep = err & pe & se;
        @(negedge clk);
        perr_en = pe; serr_en = se; bus_master = master;
        addr_phase = 1; frame_n = 0; ad = a; cbe_n = c;
        @(negedge clk);
        addr_phase = 0; par = p; ad = ~a;  // R2: new AD lines must not matter
        @(negedge clk);
        check("R5 inhibit after address", devsel_inhibit, rep);
        check("R4 serr not yet", serr_n, 1'b1);
        if (clr_same) begin clr_dpe = 1; clr_sse = 1; end
        @(negedge clk);
        clr_dpe = 0; clr_sse = 0;
        check("R4 serr pulse", serr_n, ~rep);
        check("R3 dpe from address R1 R2", stat_dpe, err);
        check("R4 sse", stat_sse, rep);
        @(negedge clk);
        check("R4 serr one clock", serr_n, 1'b1);
        check("R5 inhibit held", devsel_inhibit, rep);
        check("R9 dpe sticky", stat_dpe, err);
        frame_n = 1; irdy_n = 1;
        @(negedge clk);
        check("R5 inhibit released", devsel_inhibit, 1'b0);
        clear_flags();
    endtask

    task automatic data_txn(input logic pe, input int flip, input logic master,
                            input logic wr, input logic trdy_hold);
        logic [31:0] a;
        logic [3:0]  c;
        logic        p, err, rep, act;
        a = 32'h6A09E667 * (flip + 7) ^ {30'h0, pe, wr};
        c = 4'(flip * 3 + 1);
        p = ^{a, c};
        if (flip < 32)      a[flip] = ~a[flip];
        else if (flip < 36) c[flip-32] = ~c[flip-32];
        else if (flip == 36) p = ~p;
        act = wr & !master & !trdy_hold;
        err = (flip != 37) && act;
        rep = err & pe;
        @(negedge clk);
        perr_en = pe; serr_en = 1; bus_master = master; wr_cmd = wr;
        frame_n = 1; irdy_n = 0; trdy_n = trdy_hold; ad = a; cbe_n = c;
        @(negedge clk);
        irdy_n = 1; trdy_n = 1; par = p; ad = ~a;
        check("R8 oe at data phase", perr_oe, wr & !master);
        @(negedge clk);
        check("R7 perr not yet", perr_n, 1'b1);
        check("R8 oe in pipeline", perr_oe, act);
        @(negedge clk);
        check("R7 perr pulse R6", perr_n, ~rep);
        check("R3 dpe from data", stat_dpe, err);
        check("R4 no sse on data error", stat_sse, 1'b0);
        check("R8 oe during check", perr_oe, act);
        @(negedge clk);
        check("R7 perr one clock", perr_n, 1'b1);
        check("R8 drive high after pulse", perr_oe, rep);
        @(negedge clk);
        check("R8 oe released", perr_oe, 1'b0);
        wr_cmd = 0;
        clear_flags();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; ad = 0; cbe_n = 0; par = 0; perr_en = 0; serr_en = 0;
        idle_bus();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10 perr_n", perr_n, 1'b1);
        check("R10 serr_n", serr_n, 1'b1);
        check("R10 perr_oe", perr_oe, 1'b0);
        check("R10 inhibit", devsel_inhibit, 1'b0);
        check("R10 dpe", stat_dpe, 1'b0);
        check("R10 sse", stat_sse, 1'b0);

        // Sweep every flipped line under every enable pair (R1 R3 R4 R5)
        for (int en = 0; en < 4; en++)
            for (int f = 0; f < 38; f++)
                addr_txn(en[1], en[0], f, 1'b0, 1'b0);
        // Own address phases are not checked (R1)
        for (int f = 30; f < 38; f++) addr_txn(1'b1, 1'b1, f, 1'b1, 1'b0);
        // Set and clear on the same edge: set wins (R9)
        addr_txn(1'b1, 1'b1, 5, 1'b0, 1'b1);
        addr_txn(1'b1, 1'b1, 36, 1'b0, 1'b1);

        // Data sweep (R6 R7 R8)
        for (int pe = 0; pe < 2; pe++)
            for (int f = 0; f < 38; f++)
                data_txn(pe[0], f, 1'b0, 1'b1, 1'b0);
        // Ignored data phases: read, own master, no TRDY# (R6)
        for (int f = 34; f < 38; f++) begin
            data_txn(1'b1, f, 1'b0, 1'b0, 1'b0);
            data_txn(1'b1, f, 1'b1, 1'b1, 1'b0);
            data_txn(1'b1, f, 1'b0, 1'b1, 1'b1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule